// File: doc/BRIEF.md
# Eight-Slice Digit Accumulate Stage

This stage adds the products of eight digit slices of a coefficient-reconfigurable FIR filter to a running partial sum and produces one 24-bit filter word per sample clock. Each slice delivers a 14-bit magnitude field and a separate sign bit, which together form a 15-bit two's-complement value. The stage never widens the eight slice values to 24 bits. It derives one 10-bit correction word from the eight sign bits and adds it once, at weight 2^14.

The 24-bit partial-sum register is loaded serially through a scan input while a scan enable is high, least significant bit first. The first stage of a cascade loads it with a compensation constant: the number of negative digits in the configuration, at LSB weight. That constant completes the ones'-complement negations made in the slices. A later stage loads it with the partial sum of the stage before it. Outside scan the register holds its value. The sum is registered on every clock.

Top module: `dacc_stage`

## Requirements
- R1: Each cycle the stage computes the partial-sum register plus the eight slice values, modulo 2^24. Slice j's value is the 15-bit two's-complement number whose bit 14 is sign bit j and whose bits 13..0 are addend field j. Field j occupies bits 14j+13..14j of `addends`.
- R2: `y` shows the result for the inputs present before a rising clock edge from that edge onward, one register stage of latency.
- R3: The 7 upper bits of the correction word are all ones when at least one sign bit is 1 and all zeros when none is. All-negative and all-non-negative sign patterns therefore sum correctly.
- R4: The 3 low bits of the correction word equal the count of zero sign bits modulo 8. The correction word is therefore 1024 minus the number of negative slices, modulo 1024.
- R5: While `scan_en` is high, each clock shifts `scan_in` into bit 23 of the partial-sum register and moves every bit one place down. After 24 such clocks, the first bit shifted in sits at bit 0.
- R6: While `scan_en` is low the partial-sum register keeps its value across any number of samples.
- R7: A synchronous active-high `rst` clears the partial-sum register and `y` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Shift the partial-sum register one place per clock |
| scan_in | input | 1 | Serial data for the partial-sum register, LSB first |
| addends | input | 112 | Eight 14-bit slice magnitude fields, slice 0 in the low bits |
| signs | input | 8 | Sign bit of each slice, slice 0 in bit 0 |
| y | output | 24 | Registered 24-bit stage result |

## Verification
Every sum is due exactly one rising edge after its inputs are applied. The bench stamps each expected word with the cycle count at which it becomes valid and compares it half a period after that edge. A scan load needs 24 clocks before the loaded value can take part in a sum, so the expected value changes only after the whole load is complete. The bench computes the reference by sign-extending each slice to 24 bits and adding directly. It uses all-zero, all-one and random sign patterns, and back-to-back samples that change every cycle.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    localparam int NSLICE = 8;
    localparam int ADD_W  = 14;
    localparam int ACC_W  = 24;
    localparam int HI_W   = ACC_W - ADD_W;
    localparam int CNT_W  = $clog2(NSLICE + 1);
    localparam int LOW_W  = $clog2(NSLICE);

    typedef logic [ADD_W-1:0] addend_t;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [ADD_W-1:0] lo;
    } acc_word_t;

    function automatic logic [CNT_W-1:0] count_clear(input logic [NSLICE-1:0] s);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int k = 0; k < NSLICE; k++) begin
            n = n + CNT_W'(!s[k]);
        end
        return n;
    endfunction
endpackage

// File: rtl/dacc_sext_gen.sv
module dacc_sext_gen
    import dacc_pkg::*;
(
    input  logic [NSLICE-1:0] sign_bits,
    output logic [HI_W-1:0]   sx_word
);
    logic [CNT_W-1:0] clear_cnt;
    logic             any_neg;

    always_comb begin
        clear_cnt = count_clear(sign_bits);
        any_neg   = |sign_bits;
        sx_word   = {{(HI_W-LOW_W){any_neg}}, clear_cnt[LOW_W-1:0]};
    end
endmodule

// File: rtl/dacc_scan_reg.sv
module dacc_scan_reg
    import dacc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      shift_en,
    input  logic      ser_in,
    output acc_word_t word_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= acc_word_t'({ser_in, word_q[ACC_W-1:1]});
        end
    end
endmodule

// File: rtl/dacc_sum.sv
module dacc_sum
    import dacc_pkg::*;
(
    input  addend_t             terms [NSLICE],
    input  acc_word_t           acc,
    input  logic [HI_W-1:0]     sx_word,
    output logic [ACC_W-1:0]    total
);
    logic [ACC_W-1:0] low_part;
    logic [HI_W-1:0]  high_part;

    always_comb begin
        low_part = ACC_W'(acc.lo);
        for (int j = 0; j < NSLICE; j++) begin
            low_part = low_part + ACC_W'(terms[j]);
        end
        high_part = acc.hi + sx_word;
        total     = low_part + {high_part, {ADD_W{1'b0}}};
    end
endmodule

// File: rtl/dacc_stage.sv
module dacc_stage
    import dacc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scan_en,
    input  logic                    scan_in,
    input  logic [NSLICE*ADD_W-1:0] addends,
    input  logic [NSLICE-1:0]       signs,
    output logic [ACC_W-1:0]        y
);
    addend_t          terms [NSLICE];
    acc_word_t        acc_q;
    logic [HI_W-1:0]  sx_w;
    logic [ACC_W-1:0] sum_c;

    for (genvar g = 0; g < NSLICE; g++) begin : g_unpack
        assign terms[g] = addends[g*ADD_W +: ADD_W];
    end

    dacc_sext_gen u_sext (
        .sign_bits (signs),
        .sx_word   (sx_w)
    );

    dacc_scan_reg u_acc (
        .clk      (clk),
        .rst      (rst),
        .shift_en (scan_en),
        .ser_in   (scan_in),
        .word_q   (acc_q)
    );

    dacc_sum u_sum (
        .terms   (terms),
        .acc     (acc_q),
        .sx_word (sx_w),
        .total   (sum_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            y <= '0;
        end else begin
            y <= sum_c;
        end
    end
endmodule

// File: rtl/dacc_stage_chk.sv
module dacc_stage_chk
    import dacc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scan_en,
    input logic              scan_in,
    input logic [NSLICE-1:0] signs,
    input logic [ACC_W-1:0]  acc_q,
    input logic [HI_W-1:0]   sx
);
    a_r5_scan_top: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> acc_q[ACC_W-1] == $past(scan_in));

    a_r5_scan_move: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> acc_q[ACC_W-2:0] == $past(acc_q[ACC_W-1:1]));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(acc_q));

    a_r3_sext_upper: assert property (@(posedge clk) disable iff (rst)
        sx[HI_W-1:LOW_W] == ((signs != '0) ? {(HI_W-LOW_W){1'b1}} : '0));

    a_r4_sext_low: assert property (@(posedge clk) disable iff (rst)
        sx[LOW_W-1:0] == LOW_W'(NSLICE - $countones(signs)));
endmodule

bind dacc_stage dacc_stage_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .scan_en (scan_en),
    .scan_in (scan_in),
    .signs   (signs),
    .acc_q   (acc_q),
    .sx      (sx_w)
);

// File: tb/dacc_stage_tb.sv
`timescale 1ns/1ps
module dacc_stage_tb;
    import dacc_pkg::*;

    typedef struct {
        logic [ACC_W-1:0] exp;
        int               due;
        string            tag;
    } item_t;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    scan_en = 1'b0;
    logic                    scan_in = 1'b0;
    logic [NSLICE*ADD_W-1:0] addends = '0;
    logic [NSLICE-1:0]       signs = '0;
    logic [ACC_W-1:0]        y;

    item_t            sb [$];
    int               cyc = 0;
    int               n_chk = 0;
    int               n_bad = 0;
    logic [ACC_W-1:0] acc_model = '0;
    bit               done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dacc_stage u_dut (
        .clk     (clk),
        .rst     (rst),
        .scan_en (scan_en),
        .scan_in (scan_in),
        .addends (addends),
        .signs   (signs),
        .y       (y)
    );

    task automatic check(input string tag, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
        end
    endtask

    function automatic logic [ACC_W-1:0] ref_sum(input logic [NSLICE*ADD_W-1:0] a,
                                                 input logic [NSLICE-1:0] s,
                                                 input logic [ACC_W-1:0] acc);
        logic [ACC_W-1:0] r;
        r = acc;
        for (int j = 0; j < NSLICE; j++) begin
            r = r + {{(ACC_W-ADD_W){s[j]}}, a[j*ADD_W +: ADD_W]};
        end
        return r;
    endfunction

    task automatic apply(input logic [NSLICE*ADD_W-1:0] a, input logic [NSLICE-1:0] s, input string tag);
        item_t it;
        @(negedge clk);
        addends = a;
        signs   = s;
        it.exp  = ref_sum(a, s, acc_model);
        it.due  = cyc + 1;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic scan_load(input logic [ACC_W-1:0] v);
        for (int i = 0; i < ACC_W; i++) begin
            @(negedge clk);
            scan_en = 1'b1;
            scan_in = v[i];
        end
        @(negedge clk);
        scan_en = 1'b0;
        scan_in = 1'b0;
        acc_model = v;
    endtask

    function automatic logic [NSLICE*ADD_W-1:0] rand_add();
        logic [NSLICE*ADD_W-1:0] r;
        for (int j = 0; j < NSLICE; j++) r[j*ADD_W +: ADD_W] = ADD_W'($urandom);
        return r;
    endfunction

    // Monitor: compares the head of the scoreboard once its due cycle is reached.
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            if (it.due == cyc) check(it.tag, y, it.exp);
            else check({it.tag, " (missed)"}, 'x, it.exp);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check("R7 reset output", y, '0);

        apply('0, '0, "R7 cleared register");
        // Load a compensation constant, then read it back with zero slices.
        scan_load(24'h000005);
        apply('0, '0, "R5 compensation load");
        apply({NSLICE*ADD_W{1'b1}}, '1, "R3 all negative max field");
        apply(rand_add(), '1, "R3 all negative random");
        apply(rand_add(), '0, "R4 all non-negative");
        apply({NSLICE*ADD_W{1'b1}}, '0, "R4 all non-negative max field");
        apply('0, 8'h01, "R4 one negative");
        apply('0, 8'h7F, "R4 seven negative");
        // Back-to-back samples changing each cycle, register held (R6).
        for (int k = 0; k < 40; k++) begin
            apply(rand_add(), NSLICE'($urandom), "R1 R2 R6 random back-to-back");
        end
        // Cascade: load a preceding stage's partial sum.
        scan_load(24'hABCDEF);
        apply('0, '0, "R5 partial sum load");
        apply(rand_add(), 8'hA5, "R1 after cascade load");
        scan_load(24'hFFFFFF);
        apply('0, 8'h01, "R1 wrap modulo 2^24");
        apply({NSLICE*ADD_W{1'b1}}, '0, "R1 wrap carry out");
        for (int k = 0; k < 20; k++) begin
            apply(rand_add(), NSLICE'($urandom), "R6 hold across samples");
        end
        // Reset clears the partial-sum register.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1 check("R7 reset output", y, '0);
        rst = 1'b0;
        acc_model = '0;
        apply('0, '0, "R7 register cleared by reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule